// File: doc/BRIEF.md
# Link Mode Configuration Latch

This block holds the link configuration that software prepares for an infrared physical layer and hands it over only at one controlled moment. Software writes a pending configuration word (mode select, CRC width, transmit and receive enables, loopback and several line options) and a pending physical-layer word (baud divisor, pulse width and preamble length). Writing these has no effect on the applied mode. The pending values are applied only when software drives the link-enable bit from 0 to 1.

At that rising edge the block checks that no more than one of the three mode bits is set. If the check passes, the selected mode and the CRC width become the applied state. If it fails, a configuration error flag is raised and no mode is applied. In both cases the pending physical-layer word is copied to the current physical-layer output. Clearing the link-enable bit turns every mode-on flag off. The transmit and receive status flags follow the pending configuration at all times. Receive is reported as enabled only when transmit is off or loopback is on.

All state is visible at the ports: the packed status word, the individual applied flags, the current physical-layer word and the pending configuration.

Top module: `link_mode_latch`

## Requirements
- R1: After synchronous reset, every output is zero: pending configuration, current physical-layer word, status word and all flags.
- R2: A write with `wr_sel` 0 stores `wr_data` as the pending configuration, which is visible on `cfg_rd` after the write edge. A write with `wr_sel` 1 stores the pending physical-layer word. Neither write changes `mode_on`, `crc16_on`, `cfg_err` or `phy_cur`. A write with `wr_sel` 3 changes nothing.
- R3: A write with `wr_sel` 2 sets the link enable from `wr_data[15]`. When this takes it from 0 to 1 and at most one of configuration bits 4, 5 and 6 is set, those bits go to `mode_on[0]`, `mode_on[1]` and `mode_on[2]`, bit 7 goes to `crc16_on`, and `cfg_err` clears, all on that same edge.
- R4: On a 0-to-1 link enable edge with two or more of configuration bits 4..6 set, `cfg_err` becomes 1 while `mode_on` and `crc16_on` become 0.
- R5: On every 0-to-1 link enable edge, `phy_cur` takes the pending physical-layer word. That word holds baud in [15:10], pulse width in [9:5] and preamble in [4:0]. At no other time does `phy_cur` change.
- R6: A 1-to-0 link enable edge clears `mode_on` and `crc16_on` and leaves `cfg_err` unchanged.
- R7: Writing 1 to the link enable while it is already 1 applies nothing. A pending change made while the link is on stays invisible on `mode_on`, `crc16_on` and `phy_cur`.
- R8: `tx_on` equals configuration bit 12 at all times.
- R9: `rx_on` equals configuration bit 11 AND (NOT bit 12 OR loopback bit 14) at all times.
- R10: `stat_word` has the link enable at bit 15, `cfg_err` at 14, `mode_on[2]` at 13, `mode_on[1]` at 12, `mode_on[0]` at 11, `tx_on` at 10, `rx_on` at 9 and `crc16_on` at 8. Bits [7:0] read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 configuration, 1 physical-layer word, 2 link enable, 3 none |
| wr_data | input | 16 | Write data |
| cfg_rd | output | 16 | Pending configuration word |
| phy_cur | output | 16 | Applied physical-layer word |
| stat_word | output | 16 | Packed enable and status word, low byte zero |
| link_on | output | 1 | Link enable bit |
| cfg_err | output | 1 | Configuration error flag |
| mode_on | output | 3 | Applied mode flags (slow, medium, fast) |
| crc16_on | output | 1 | Applied 16-bit CRC flag |
| tx_on | output | 1 | Transmit enabled status |
| rx_on | output | 1 | Receive enabled status |

## Verification
A wrong edge detector or a stale pending register shows up on `mode_on`, `crc16_on` and `phy_cur` in the first cycle after the write that should have applied a configuration, or that should not have. A mis-set or lost error flag appears on `cfg_err` and on bit 14 of `stat_word` one edge after the rising enable. The reference model is compared against every output after every clock, so any wrong field placement or wrong enable decode is reported within one cycle of the write that exposes it.

// File: rtl/lml_pkg.sv
package lml_pkg;

    localparam int WORD_W   = 16;
    localparam int MODE_N   = 3;
    localparam int SEL_W    = 2;

    // configuration word bit positions
    localparam int POS_MODE  = 4;   // three mode bits start here
    localparam int POS_CRC16 = 7;
    localparam int POS_RXEN  = 11;
    localparam int POS_TXEN  = 12;
    localparam int POS_LOOP  = 14;

    // status word bit positions
    localparam int ST_LINK  = 15;
    localparam int ST_ERR   = 14;
    localparam int ST_MODE  = 11;   // mode_on[0] at 11 .. mode_on[2] at 13
    localparam int ST_TX    = 10;
    localparam int ST_RX    = 9;
    localparam int ST_CRC   = 8;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG  = 2'd0,
        SEL_PHY  = 2'd1,
        SEL_LINK = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef struct packed {
        logic              link;
        logic              err;
        logic [MODE_N-1:0] mode;
        logic              crc16;
    } applied_t;

    function automatic logic [MODE_N-1:0] mode_field(input logic [WORD_W-1:0] cfg);
        return cfg[POS_MODE +: MODE_N];
    endfunction

    function automatic logic mode_legal(input logic [MODE_N-1:0] m);
        int n;
        n = 0;
        for (int i = 0; i < MODE_N; i++) n += int'(m[i]);
        return n <= 1;
    endfunction

    function automatic logic rx_status(input logic [WORD_W-1:0] cfg);
        return cfg[POS_RXEN] & (~cfg[POS_TXEN] | cfg[POS_LOOP]);
    endfunction

endpackage

// File: rtl/lml_pending_regs.sv
module lml_pending_regs
    import lml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wsel_e             wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] cfg_q,
    output logic [WORD_W-1:0] phy_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            phy_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CFG: cfg_q <= wr_data;
                SEL_PHY: phy_q <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/lml_apply.sv
module lml_apply
    import lml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wsel_e             wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] cfg_q,
    input  logic [WORD_W-1:0] phy_q,
    output applied_t          app_q,
    output logic [WORD_W-1:0] phy_cur_q
);

    logic link_nxt;
    logic rise;
    logic fall;
    logic legal;

    assign link_nxt = (wr_en && wr_sel == SEL_LINK) ? wr_data[ST_LINK] : app_q.link;
    assign rise     = link_nxt & ~app_q.link;
    assign fall     = ~link_nxt & app_q.link;
    assign legal    = mode_legal(mode_field(cfg_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            app_q     <= '0;
            phy_cur_q <= '0;
        end else begin
            app_q.link <= link_nxt;
            if (rise) begin
                phy_cur_q <= phy_q;
                app_q.err <= ~legal;
                if (legal) begin
                    app_q.mode  <= mode_field(cfg_q);
                    app_q.crc16 <= cfg_q[POS_CRC16];
                end else begin
                    app_q.mode  <= '0;
                    app_q.crc16 <= 1'b0;
                end
            end else if (fall) begin
                app_q.mode  <= '0;
                app_q.crc16 <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lml_status.sv
module lml_status
    import lml_pkg::*;
(
    input  applied_t          app,
    input  logic [WORD_W-1:0] cfg_q,
    output logic              tx_st,
    output logic              rx_st,
    output logic [WORD_W-1:0] stat
);

    assign tx_st = cfg_q[POS_TXEN];
    assign rx_st = rx_status(cfg_q);

    always_comb begin
        stat                       = '0;
        stat[ST_LINK]              = app.link;
        stat[ST_ERR]               = app.err;
        stat[ST_TX]                = tx_st;
        stat[ST_RX]                = rx_st;
        stat[ST_CRC]               = app.crc16;
        for (int i = 0; i < MODE_N; i++) begin
            stat[ST_MODE + i] = app.mode[i];
        end
    end

endmodule

// File: rtl/link_mode_latch.sv
module link_mode_latch
    import lml_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [15:0]       wr_data,
    output logic [15:0]       cfg_rd,
    output logic [15:0]       phy_cur,
    output logic [15:0]       stat_word,
    output logic              link_on,
    output logic              cfg_err,
    output logic [2:0]        mode_on,
    output logic              crc16_on,
    output logic              tx_on,
    output logic              rx_on
);

    wsel_e             sel;
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] phy_q;
    applied_t          app_q;

    assign sel = wsel_e'(wr_sel);

    lml_pending_regs u_pend (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .phy_q   (phy_q)
    );

    lml_apply u_apply (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (sel),
        .wr_data   (wr_data),
        .cfg_q     (cfg_q),
        .phy_q     (phy_q),
        .app_q     (app_q),
        .phy_cur_q (phy_cur)
    );

    lml_status u_stat (
        .app   (app_q),
        .cfg_q (cfg_q),
        .tx_st (tx_on),
        .rx_st (rx_on),
        .stat  (stat_word)
    );

    assign cfg_rd   = cfg_q;
    assign link_on  = app_q.link;
    assign cfg_err  = app_q.err;
    assign mode_on  = app_q.mode;
    assign crc16_on = app_q.crc16;

endmodule

// File: rtl/link_mode_latch_chk.sv
module link_mode_latch_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cfg_rd,
    input logic [15:0] phy_cur,
    input logic [15:0] stat_word,
    input logic        link_on,
    input logic        cfg_err,
    input logic [2:0]  mode_on,
    input logic        crc16_on,
    input logic        rx_on
);

    AST_ERR_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (link_on && !$past(link_on)) |-> (cfg_err == ($countones($past(cfg_rd[6:4])) > 1))); // R4

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mode_on)); // R3

    AST_ERR_NO_MODE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (mode_on == 3'b000 && !crc16_on)); // R4

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !link_on |-> (mode_on == 3'b000 && !crc16_on)); // R6

    AST_PHY_HELD: assert property (@(posedge clk) disable iff (rst)
        (link_on && $past(link_on)) |-> $stable(phy_cur)); // R5

    AST_PHY_HELD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!link_on && $past(!link_on)) |-> $stable(phy_cur)); // R5

    AST_RX_RULE: assert property (@(posedge clk) disable iff (rst)
        rx_on == (cfg_rd[11] && (!cfg_rd[12] || cfg_rd[14]))); // R9

    AST_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        stat_word[7:0] == 8'h00); // R10

endmodule

bind link_mode_latch link_mode_latch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_rd    (cfg_rd),
    .phy_cur   (phy_cur),
    .stat_word (stat_word),
    .link_on   (link_on),
    .cfg_err   (cfg_err),
    .mode_on   (mode_on),
    .crc16_on  (crc16_on),
    .rx_on     (rx_on)
);

// File: tb/link_mode_latch_tb.sv
`timescale 1ns/1ps
module link_mode_latch_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] cfg_rd, phy_cur, stat_word;
    logic        link_on, cfg_err, crc16_on, tx_on, rx_on;
    logic [2:0]  mode_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_cfg, m_phy, m_phycur;
    logic        m_link, m_err, m_crc;
    logic [2:0]  m_mode;

    always #2 clk = ~clk;

    link_mode_latch u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cfg_rd(cfg_rd), .phy_cur(phy_cur), .stat_word(stat_word),
        .link_on(link_on), .cfg_err(cfg_err), .mode_on(mode_on),
        .crc16_on(crc16_on), .tx_on(tx_on), .rx_on(rx_on)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ones(input logic [2:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]);
    endfunction

    task automatic model_reset();
        m_cfg = 0; m_phy = 0; m_phycur = 0;
        m_link = 0; m_err = 0; m_crc = 0; m_mode = 0;
    endtask

    task automatic model_step(input logic we, input logic [1:0] sel, input logic [15:0] d);
        logic nl;
        nl = m_link;
        if (we && sel == 2'd2) nl = d[15];
        if (nl && !m_link) begin
            m_phycur = m_phy;
            if (ones(m_cfg[6:4]) > 1) begin
                m_err = 1; m_mode = 0; m_crc = 0;
            end else begin
                m_err = 0; m_mode = m_cfg[6:4]; m_crc = m_cfg[7];
            end
        end else if (!nl && m_link) begin
            m_mode = 0; m_crc = 0;
        end
        m_link = nl;
        if (we && sel == 2'd0) m_cfg = d;
        if (we && sel == 2'd1) m_phy = d;
    endtask

    task automatic compare_all();
        logic        erx;
        logic [15:0] est;
        erx = m_cfg[11] && (!m_cfg[12] || m_cfg[14]);
        est = {m_link, m_err, m_mode[2], m_mode[1], m_mode[0], m_cfg[12], erx, m_crc, 8'h00};
        chk("R2", "cfg_rd", int'(cfg_rd), int'(m_cfg));
        chk("R5", "phy_cur", int'(phy_cur), int'(m_phycur));
        chk("R3", "mode_on", int'(mode_on), int'(m_mode));
        chk("R3", "crc16_on", int'(crc16_on), int'(m_crc));
        chk("R4", "cfg_err", int'(cfg_err), int'(m_err));
        chk("R8", "tx_on", int'(tx_on), int'(m_cfg[12]));
        chk("R9", "rx_on", int'(rx_on), int'(erx));
        chk("R10", "stat_word", int'(stat_word), int'(est));
        chk("R6", "link_on", int'(link_on), int'(m_link));
    endtask

    // one clock with optional write; compare after edge
    task automatic cyc(input logic we, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk);
        #1;
        model_step(we, sel, d);
        compare_all();
        wr_en = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        cyc(1'b1, sel, d);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        chk("R1", "stat_word", int'(stat_word), 0);
        chk("R1", "phy_cur", int'(phy_cur), 0);
        chk("R1", "cfg_rd", int'(cfg_rd), 0);
        chk("R1", "flags", int'({link_on, cfg_err, mode_on, crc16_on, tx_on, rx_on}), 0);
        cyc(0, 0, 0);

        // R2: pending writes not applied; R8 tx live
        wr(2'd0, 16'h1090);         // tx, crc16, slow mode
        wr(2'd1, 16'hA5C3);
        chk("R2", "mode before enable", int'(mode_on), 0);
        chk("R2", "phy before enable", int'(phy_cur), 0);
        // R3 R5: rise applies
        wr(2'd2, 16'h8000);
        chk("R3", "slow mode applied", int'(mode_on), 1);
        chk("R5", "phy copied", int'(phy_cur), 16'hA5C3);
        // R7: change while on is invisible
        wr(2'd0, 16'h0040);
        wr(2'd1, 16'h1234);
        wr(2'd2, 16'h8000);
        chk("R7", "no reapply mode", int'(mode_on), 1);
        chk("R7", "no reapply phy", int'(phy_cur), 16'hA5C3);
        // R6: fall clears
        wr(2'd2, 16'h0000);
        chk("R6", "fall clears mode", int'(mode_on), 0);
        // R2: sel 3 ignored
        wr(2'd3, 16'hFFFF);
        chk("R2", "sel3 ignored cfg", int'(cfg_rd), 16'h0040);
        // R3: rise with fast mode
        wr(2'd2, 16'h8000);
        chk("R3", "fast mode", int'(mode_on), 4);
        chk("R5", "phy copied second", int'(phy_cur), 16'h1234);
        wr(2'd2, 16'h0000);
        // R4: multiple modes
        wr(2'd0, 16'h00F0);
        wr(2'd1, 16'hFC1F);
        wr(2'd2, 16'h8000);
        chk("R4", "err set", int'(cfg_err), 1);
        chk("R4", "no mode on err", int'(mode_on), 0);
        chk("R5", "phy copied on err", int'(phy_cur), 16'hFC1F);
        wr(2'd2, 16'h0000);
        chk("R6", "err held after fall", int'(cfg_err), 1);
        // R3: valid rise clears err, medium mode + crc
        wr(2'd0, 16'h00A0);
        wr(2'd2, 16'h8000);
        chk("R3", "err cleared", int'(cfg_err), 0);
        chk("R3", "medium mode", int'(mode_on), 2);
        chk("R3", "crc16 on", int'(crc16_on), 1);
        wr(2'd2, 16'h0000);
        // R8 R9: rx/tx/loop combinations
        for (int k = 0; k < 8; k++) begin
            logic [15:0] c;
            c = 16'h0;
            c[11] = k[0]; c[12] = k[1]; c[14] = k[2];
            wr(2'd0, c);
            chk("R9", "rx rule", int'(rx_on), int'(k[0] && (!k[1] || k[2])));
            chk("R8", "tx live", int'(tx_on), int'(k[1]));
        end
        // mixed stimulus compared every clock against model
        for (int n = 0; n < 400; n++) begin
            logic [15:0] d;
            logic [1:0]  s;
            d = 16'($urandom);
            s = 2'($urandom_range(0, 3));
            cyc(1'($urandom_range(0, 1)), s, d);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule